// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit data pointers for an 8-bit microcontroller core and turns pointer-based move instructions into a memory address. A one-bit select in a configuration register decides which physical pointer acts as the primary operand. The other physical pointer then serves as the alternate operand. Each pointer has its own direction bit and its own auto-update enable. A move can therefore step the pointer it used, up or down, without a separate instruction.

The instruction decoder drives one strobe per instruction for the duration of that instruction: an external-data move, a code read, or a pointer increment. The decoder also drives a flag that marks an alternate-pointer operand. During the strobe the unit presents the address, the target space and the choice of data register. The pointer's new value takes effect at the clock edge that ends the strobe. Software reaches the configuration and the four pointer bytes through a byte-wide special-function-register bus. A separate redirect input makes B, instead of A, the data register for external-data moves that go through physical pointer 1.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset, the configuration reads 00h, both pointers read 0000h, and with no strobe active the space is external data (code 0) and the data register is A (`mem_dreg_b` = 0).
- R2: The configuration register sits at SFR address A2h. Bit 0 is the select, bit 3 is signature enable, bit 4 is pointer 0 down, bit 5 is pointer 1 down, bit 6 is pointer 0 auto-update and bit 7 is pointer 1 auto-update. Bits 2 and 1 always read 0, and a write to them has no effect.
- R3: The physical pointer used is select XOR `op_alt`. During a move strobe, `mem_addr` carries that pointer's value from before the instruction.
- R4: After a move (external-data or code read), the pointer used changes at the end of the strobe only if its auto-update bit is 1. It changes by +1 when its down bit is 0 and by -1 when the down bit is 1. When auto-update is 0 the pointer is unchanged.
- R5: An increment strobe changes the pointer used by +1 when its down bit is 0 and by -1 when the down bit is 1, whatever the auto-update bit holds.
- R6: Pointer arithmetic wraps modulo 65536: FFFFh + 1 = 0000h and 0000h - 1 = FFFFh.
- R7: `mem_space` is 0 (external data) for external-data moves. It is 1 (code) for code reads when signature enable is 0, and 2 (signature) for code reads when signature enable is 1.
- R8: `mem_dreg_b` is 1 only when an external-data move uses physical pointer 1 while `redir_b` is 1. `mem_wdata` then carries `acc_b`; in every other case it carries `acc_a`.
- R9: An SFR write to a byte of a pointer in the same cycle as that pointer's update takes priority. The written byte takes the bus value, the other byte keeps its old value, and no step is applied.
- R10: Pointer bytes read and write at 82h (pointer 0 low), 83h (pointer 0 high), 84h (pointer 1 low) and 85h (pointer 1 high). `sfr_rdata` reads 00h at any other address.
- R11: An instruction never changes the pointer it does not use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read-back data for the addressed register |
| op_xdata | input | 1 | External-data move strobe |
| op_code | input | 1 | Code-read move strobe |
| op_inc | input | 1 | Pointer increment strobe |
| op_alt | input | 1 | Operand is the alternate pointer |
| redir_b | input | 1 | Redirect external-data moves through pointer 1 to B |
| acc_a | input | 8 | Value of register A |
| acc_b | input | 8 | Value of register B |
| mem_addr | output | 16 | Memory address for the current move |
| mem_space | output | 2 | Target space: 0 external data, 1 code, 2 signature |
| mem_dreg_b | output | 1 | Data register is B (1) or A (0) |
| mem_wdata | output | 8 | Store data taken from the selected register |

## Verification
Every cycle, the assertions check the following:
- A stepping pointer lands exactly one away from its previous value, with wrap.
- An idle pointer holds its value.
- A byte write overrides the step and leaves the other byte alone.
- The two pointers never step together.
- B is selected only for external-data moves under redirect.
- A configuration write keeps its reserved bits at zero.

Only the bench's sweep can show the following:
- The physical pointer that each combination of select and alternate operand picks.
- The step that follows from each pairing of direction and enable bits on that pointer.
- The space that a code read reaches when signature enable is set.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    typedef enum logic [1:0] {
        SPC_XDATA = 2'd0,
        SPC_CODE  = 2'd1,
        SPC_SIG   = 2'd2
    } space_e;

    // Stored configuration fields; reserved bits are not kept.
    typedef struct packed {
        logic upd1;
        logic upd0;
        logic dn1;
        logic dn0;
        logic sig;
        logic sel;
    } cfg_t;

    localparam logic [7:0] CFG_MASK = 8'hF9;

    function automatic logic [7:0] cfg_to_byte(cfg_t c);
        return {c.upd1, c.upd0, c.dn1, c.dn0, c.sig, 2'b00, c.sel};
    endfunction

    function automatic cfg_t byte_to_cfg(logic [7:0] b);
        cfg_t c;
        c.upd1 = b[7];
        c.upd0 = b[6];
        c.dn1  = b[5];
        c.dn0  = b[4];
        c.sig  = b[3];
        c.sel  = b[0];
        return c;
    endfunction

endpackage

// File: rtl/dptr_cfg.sv
module dptr_cfg
    import dptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output cfg_t       cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = byte_to_cfg(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_to_byte(cfg_q) == ($past(wdata) & CFG_MASK));

endmodule

// File: rtl/dptr_ptr.sv
module dptr_ptr #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  step,
    input  logic                  down,
    output logic [2*BYTE_W-1:0]   ptr_o
);

    localparam int PTR_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.lo = wdata;
            if (wr_hi) st_d.hi = wdata;
        end else if (step) begin
            st_d = down ? ptr_t'(st_q - PTR_W'(1)) : ptr_t'(st_q + PTR_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q;

    // R4 R5 R6
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !down && !wr_lo && !wr_hi) |=> ptr_o == $past(ptr_o) + PTR_W'(1));

    // R4 R5 R6
    step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && down && !wr_lo && !wr_hi) |=> ptr_o == $past(ptr_o) - PTR_W'(1));

    // R9
    wr_lo_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (ptr_o[BYTE_W-1:0] == $past(wdata))
                            && (ptr_o[PTR_W-1:BYTE_W] == $past(ptr_o[PTR_W-1:BYTE_W])));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_lo && !wr_hi) |=> $stable(ptr_o));

endmodule

// File: rtl/dptr_route.sv
module dptr_route
    import dptr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cfg_t                cfg,
    input  logic                op_xdata,
    input  logic                op_code,
    input  logic                op_inc,
    input  logic                op_alt,
    input  logic                redir_b,
    input  logic [2*BYTE_W-1:0] ptr0,
    input  logic [2*BYTE_W-1:0] ptr1,
    input  logic [BYTE_W-1:0]   acc_a,
    input  logic [BYTE_W-1:0]   acc_b,
    output logic [1:0]          step,
    output logic [1:0]          down,
    output logic [2*BYTE_W-1:0] addr,
    output space_e              space,
    output logic                dreg_b,
    output logic [BYTE_W-1:0]   wdata
);

    logic phys;
    logic move;

    always_comb begin
        phys    = cfg.sel ^ op_alt;
        move    = op_xdata || op_code;
        step[0] = !phys && (op_inc || (move && cfg.upd0));
        step[1] =  phys && (op_inc || (move && cfg.upd1));
        down    = {cfg.dn1, cfg.dn0};
        addr    = phys ? ptr1 : ptr0;
        if (op_code) begin
            space = cfg.sig ? SPC_SIG : SPC_CODE;
        end else begin
            space = SPC_XDATA;
        end
        dreg_b = op_xdata && redir_b && phys;
        wdata  = dreg_b ? acc_b : acc_a;
    end

    // decoder contract: at most one instruction strobe per cycle
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_xdata, op_code, op_inc}));

    // R11
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step[0] && step[1]));

    // R8
    redir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreg_b |-> (redir_b && op_xdata && addr == ptr1 && wdata == acc_b));

    // R7
    code_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_code |-> space != SPC_XDATA);

endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
    import dptr_pkg::*;
#(
    parameter int         BYTE_W   = 8,
    parameter logic [7:0] CFG_ADDR = 8'hA2,
    parameter logic [7:0] P0L_ADDR = 8'h82,
    parameter logic [7:0] P0H_ADDR = 8'h83,
    parameter logic [7:0] P1L_ADDR = 8'h84,
    parameter logic [7:0] P1H_ADDR = 8'h85
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sfr_wr,
    input  logic [7:0]          sfr_addr,
    input  logic [7:0]          sfr_wdata,
    output logic [7:0]          sfr_rdata,
    input  logic                op_xdata,
    input  logic                op_code,
    input  logic                op_inc,
    input  logic                op_alt,
    input  logic                redir_b,
    input  logic [BYTE_W-1:0]   acc_a,
    input  logic [BYTE_W-1:0]   acc_b,
    output logic [2*BYTE_W-1:0] mem_addr,
    output logic [1:0]          mem_space,
    output logic                mem_dreg_b,
    output logic [BYTE_W-1:0]   mem_wdata
);

    localparam int         NUM_PTR = 2;
    localparam int         PTR_W   = 2 * BYTE_W;
    localparam logic [7:0] LO_ADDR [NUM_PTR] = '{P0L_ADDR, P1L_ADDR};
    localparam logic [7:0] HI_ADDR [NUM_PTR] = '{P0H_ADDR, P1H_ADDR};

    cfg_t             cfg_q;
    logic [PTR_W-1:0] ptr_val [NUM_PTR];
    logic [1:0]       step;
    logic [1:0]       down;
    space_e           space;

    dptr_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sfr_wr && sfr_addr == CFG_ADDR),
        .wdata (sfr_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
        dptr_ptr #(.BYTE_W(BYTE_W)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (sfr_wr && sfr_addr == LO_ADDR[gi]),
            .wr_hi (sfr_wr && sfr_addr == HI_ADDR[gi]),
            .wdata (sfr_wdata[BYTE_W-1:0]),
            .step  (step[gi]),
            .down  (down[gi]),
            .ptr_o (ptr_val[gi])
        );
    end

    dptr_route #(.BYTE_W(BYTE_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .op_xdata (op_xdata),
        .op_code  (op_code),
        .op_inc   (op_inc),
        .op_alt   (op_alt),
        .redir_b  (redir_b),
        .ptr0     (ptr_val[0]),
        .ptr1     (ptr_val[1]),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .step     (step),
        .down     (down),
        .addr     (mem_addr),
        .space    (space),
        .dreg_b   (mem_dreg_b),
        .wdata    (mem_wdata)
    );

    assign mem_space = space;

    always_comb begin
        sfr_rdata = 8'h00;
        if (sfr_addr == CFG_ADDR) sfr_rdata = cfg_to_byte(cfg_q);
        for (int i = 0; i < NUM_PTR; i++) begin
            if (sfr_addr == LO_ADDR[i]) sfr_rdata = 8'(ptr_val[i][BYTE_W-1:0]);
            if (sfr_addr == HI_ADDR[i]) sfr_rdata = 8'(ptr_val[i][PTR_W-1:BYTE_W]);
        end
    end

endmodule

// File: tb/test_dual_ptr_unit.sv
module test_dual_ptr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        op_xdata = 1'b0;
    logic        op_code = 1'b0;
    logic        op_inc = 1'b0;
    logic        op_alt = 1'b0;
    logic        redir_b = 1'b0;
    logic [7:0]  acc_a = 8'h3C;
    logic [7:0]  acc_b = 8'hC3;
    logic [15:0] mem_addr;
    logic [1:0]  mem_space;
    logic        mem_dreg_b;
    logic [7:0]  mem_wdata;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dual_ptr_unit i_dual_ptr_unit (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .op_xdata(op_xdata),
        .op_code(op_code), .op_inc(op_inc), .op_alt(op_alt), .redir_b(redir_b),
        .acc_a(acc_a), .acc_b(acc_b), .mem_addr(mem_addr), .mem_space(mem_space),
        .mem_dreg_b(mem_dreg_b), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic read_ptr(input int n, output logic [15:0] v);
        logic [7:0] lo, hi;
        sfr_read(n == 0 ? 8'h82 : 8'h84, lo);
        sfr_read(n == 0 ? 8'h83 : 8'h85, hi);
        v = {hi, lo};
    endtask

    task automatic load_ptr(input int n, input logic [15:0] v);
        sfr_write(n == 0 ? 8'h82 : 8'h84, v[7:0]);
        sfr_write(n == 0 ? 8'h83 : 8'h85, v[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] vals [4];
        logic [15:0] v, p0, p1, ea, enew;
        logic [7:0]  rb;
        vals = '{16'h0000, 16'hFFFF, 16'h12FF, 16'hA500};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        sfr_read(8'hA2, rb); chk("R1 cfg", {8'h00, rb}, 16'h0000);
        read_ptr(0, v); chk("R1 ptr0", v, 16'h0000);
        read_ptr(1, v); chk("R1 ptr1", v, 16'h0000);
        chk("R1 space", {14'd0, mem_space}, 16'd0);
        chk("R1 dreg", {15'd0, mem_dreg_b}, 16'd0);
        // R10 unmapped address reads zero
        sfr_read(8'h90, rb); chk("R10 unmapped", {8'h00, rb}, 16'h0000);

        for (int c = 0; c < 64; c++) begin
            for (int op = 0; op < 3; op++) begin
                for (int alt = 0; alt < 2; alt++) begin
                    for (int rd = 0; rd < 2; rd++) begin
                        logic [7:0] cfgb;
                        logic sel, sig, dn0, dn1, up0, up1, phys, dn, stp, edreg;
                        logic [1:0] esp;
                        sel = c[0]; sig = c[1]; dn0 = c[2]; dn1 = c[3]; up0 = c[4]; up1 = c[5];
                        cfgb = {up1, up0, dn1, dn0, sig, 2'b00, sel};
                        p0 = vals[(c + op) % 4];
                        p1 = vals[(c + alt + rd + 1) % 4];
                        load_ptr(0, p0);
                        load_ptr(1, p1);
                        read_ptr(0, v); chk("R10 ptr0 readback", v, p0);
                        read_ptr(1, v); chk("R10 ptr1 readback", v, p1);
                        sfr_write(8'hA2, cfgb | 8'h06);
                        sfr_read(8'hA2, rb); chk("R2 cfg readback", {8'h00, rb}, {8'h00, cfgb});

                        phys = sel ^ alt[0];
                        ea   = phys ? p1 : p0;
                        dn   = phys ? dn1 : dn0;
                        stp  = (op == 2) || (phys ? up1 : up0);
                        enew = stp ? (dn ? ea - 16'd1 : ea + 16'd1) : ea;
                        esp  = (op == 1) ? (sig ? 2'd2 : 2'd1) : 2'd0;
                        edreg = (op == 0) && rd[0] && phys;

                        @(negedge clk);
                        op_xdata = (op == 0); op_code = (op == 1); op_inc = (op == 2);
                        op_alt = alt[0]; redir_b = rd[0];
                        #1;
                        if (op != 2) chk("R3 addr", mem_addr, ea);
                        chk("R7 space", {14'd0, mem_space}, {14'd0, esp});
                        chk("R8 dreg", {15'd0, mem_dreg_b}, {15'd0, edreg});
                        chk("R8 wdata", {8'h00, mem_wdata}, {8'h00, edreg ? 8'hC3 : 8'h3C});
                        @(negedge clk);
                        op_xdata = 1'b0; op_code = 1'b0; op_inc = 1'b0;
                        op_alt = 1'b0; redir_b = 1'b0;
                        read_ptr(phys ? 1 : 0, v);
                        if (stp && ((ea == 16'hFFFF && !dn) || (ea == 16'h0000 && dn)))
                            chk("R6 wrap", v, enew);
                        else if (op == 2)
                            chk("R5 inc", v, enew);
                        else
                            chk("R4 update", v, enew);
                        read_ptr(phys ? 0 : 1, v);
                        chk("R11 other ptr", v, phys ? p0 : p1);
                    end
                end
            end
        end

        // R9: low-byte write during an auto-increment wins; high byte kept
        load_ptr(0, 16'h00FF);
        sfr_write(8'hA2, 8'h40);
        @(negedge clk);
        op_xdata = 1'b1; sfr_wr = 1'b1; sfr_addr = 8'h82; sfr_wdata = 8'h40;
        #1;
        chk("R9 addr pre", mem_addr, 16'h00FF);
        @(negedge clk);
        op_xdata = 1'b0; sfr_wr = 1'b0;
        read_ptr(0, v); chk("R9 lo write wins", v, 16'h0040);

        // R9: high-byte write during a decrement on pointer 1
        load_ptr(1, 16'h3400);
        sfr_write(8'hA2, 8'hA1);
        @(negedge clk);
        op_code = 1'b1; sfr_wr = 1'b1; sfr_addr = 8'h85; sfr_wdata = 8'h77;
        @(negedge clk);
        op_code = 1'b0; sfr_wr = 1'b0;
        read_ptr(1, v); chk("R9 hi write wins", v, 16'h7700);

        // R2: all-ones write leaves reserved bits at zero
        sfr_write(8'hA2, 8'hFF);
        sfr_read(8'hA2, rb); chk("R2 reserved", {8'h00, rb}, 16'h00F9);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule